// File: doc/BRIEF.md
# SPI EEPROM Sequential Byte Reader

This block fetches a run of bytes from a small serial EEPROM over a four-wire SPI-style link. Typical contents are a station address or a board identity. The host gives a one-cycle start pulse together with a starting byte offset and a byte count. The block then drives chip select, serial clock and serial data out, and it samples serial data in. Each byte is returned on `byte_o` with a one-cycle valid strobe. A done pulse closes the run.

Each byte has its own complete transaction: the read opcode, then an 8-bit address, then eight data clocks, with chip select released in between. The first start after reset is preceded by a short warm-up of two clock pulses with the device deselected. A second mode reads the device status register instead of data. Every clock half-period lasts a parameterised number of system cycles, and the pause between transactions uses the same count.

Top module: `spi_rom_fetch`

## Requirements
- R1: Out of reset, and whenever `busy_o` is low, `cs_n_o` is 1 and `sclk_o`, `done_o` and `byte_vld_o` are 0.
- R2: The first accepted start after reset produces exactly two `sclk_o` pulses with `cs_n_o` held at 1 before chip select is first driven low. Later starts produce no such pulses.
- R3: In read mode, each transaction sends the opcode 8'h03 and then the byte address, both MSB first. This is 24 rising `sclk_o` edges in all. `mosi_o` only changes while `sclk_o` is low, and `cs_n_o` only changes while `sclk_o` is low.
- R4: `miso_i` is sampled in the low phase just before each of the last 8 rising edges of a transaction. The byte is assembled MSB first and appears on `byte_o`, with `byte_vld_o` high for one cycle, in the cycle that `cs_n_o` returns to 1.
- R5: A read of N bytes makes N separate transactions, addressed offset, offset+1, and so on. Between two transactions `cs_n_o` stays at 1 for exactly HALF_CYC cycles.
- R6: Every high and low phase of `sclk_o` lasts exactly HALF_CYC system cycles. This holds for the warm-up and for each transaction.
- R7: With `stat_mode_i` at 1 on start, one transaction sends the opcode 8'h05 with no address. It clocks in a single status byte over 16 rising edges in all. The offset and count inputs have no effect.
- R8: `busy_o` goes high in the cycle after an accepted start and stays high up to and including the single cycle in which `done_o` is high. It falls in the next cycle. `done_o` follows the last byte by HALF_CYC cycles.
- R9: A start pulse while `busy_o` is high is ignored. The bytes, addresses and transaction count of the run in progress are unchanged.
- R10: A read-mode start with count 0 makes no transaction and returns no byte, then pulses `done_o`.
- R11: The byte address wraps modulo 256 when offset plus count exceeds 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a run |
| stat_mode_i | input | 1 | 1 selects a status-register read |
| offset_i | input | 8 | First byte address of the run |
| count_i | input | CNT_W | Number of bytes to read |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| byte_o | output | 8 | Returned byte |
| byte_vld_o | output | 1 | One-cycle strobe marking `byte_o` valid |
| cs_n_o | output | 1 | Device select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the device |
| miso_i | input | 1 | Serial data from the device |

## Verification
The bench builds the block with HALF_CYC = 3 and CNT_W = 8. A half-period of three cycles makes the divider count through a non-trivial wrap, so an off-by-one in any phase, in the gap or in the sampling point shows up as a wrong measured length or a wrong bit. An 8-bit count allows runs long enough to carry the address past 255, and allows count 0. A second reset part way through brings the warm-up back into view.

// File: rtl/srf_pkg.sv
`timescale 1ns/1ps
package srf_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_LO,
    S_HI,
    S_GAP
  } srf_state_e;

  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_STAT = 8'h05;

  // rising edges per transaction and edges spent on the command part
  localparam int FRAME_RD = 24;
  localparam int FRAME_ST = 16;
  localparam int CMD_RD   = 16;
  localparam int CMD_ST   = 8;
  localparam int WORD_W   = 16;
  localparam int BIT_W    = $clog2(FRAME_RD);
endpackage

// File: rtl/srf_rst_sync.sv
`timescale 1ns/1ps
module srf_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/srf_half_timer.sv
`timescale 1ns/1ps
module srf_half_timer #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)             cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/srf_tx_shift.sv
`timescale 1ns/1ps
module srf_tx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load_i)       sr_d = word_i;
    else if (shift_i) sr_d = {sr_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign msb_o = sr_q[W-1];
endmodule

// File: rtl/srf_rx_shift.sv
`timescale 1ns/1ps
module srf_rx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_i) sr_d = {sr_q[W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign data_o = sr_q;
endmodule

// File: rtl/spi_rom_fetch.sv
`timescale 1ns/1ps
module spi_rom_fetch #(
  parameter int HALF_CYC = 4,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stat_mode_i,
  input  logic [7:0]       offset_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       byte_o,
  output logic             byte_vld_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i
);
  import srf_pkg::*;

  localparam logic [BIT_W-1:0] CMD_RD_B  = BIT_W'(CMD_RD);
  localparam logic [BIT_W-1:0] CMD_ST_B  = BIT_W'(CMD_ST);
  localparam logic [BIT_W-1:0] LAST_RD_B = BIT_W'(FRAME_RD - 1);
  localparam logic [BIT_W-1:0] LAST_ST_B = BIT_W'(FRAME_ST - 1);

  function automatic logic [WORD_W-1:0] frame_word(input logic st, input logic [7:0] a);
    return st ? {OP_STAT, 8'h00} : {OP_READ, a};
  endfunction

  logic rst_n_s;
  srf_state_e st_q, st_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [1:0] pre_q, pre_d;
  logic primed_q, primed_d;
  logic stat_q, stat_d;
  logic [7:0] addr_q, addr_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic sclk_q, sclk_d, csn_q, csn_d;
  logic done_q, done_d, vld_q, vld_d;
  logic tick, tx_load, tx_shift, rx_shift, tx_msb;
  logic [WORD_W-1:0] tx_word;
  logic [7:0] rx_data;
  logic [BIT_W-1:0] cmd_len, last_bit;

  srf_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s));

  srf_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .run_i(st_q != S_IDLE), .tick_o(tick)
  );

  srf_tx_shift #(.W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n_s), .load_i(tx_load), .word_i(tx_word),
    .shift_i(tx_shift), .msb_o(tx_msb)
  );

  srf_rx_shift #(.W(8)) u_rx (
    .clk(clk), .rst_n(rst_n_s), .shift_i(rx_shift), .bit_i(miso_i), .data_o(rx_data)
  );

  assign cmd_len  = stat_q ? CMD_ST_B : CMD_RD_B;
  assign last_bit = stat_q ? LAST_ST_B : LAST_RD_B;

  always_comb begin
    st_d     = st_q;
    bit_d    = bit_q;
    pre_d    = pre_q;
    primed_d = primed_q;
    stat_d   = stat_q;
    addr_d   = addr_q;
    left_d   = left_q;
    sclk_d   = sclk_q;
    csn_d    = csn_q;
    done_d   = 1'b0;
    vld_d    = 1'b0;
    tx_load  = 1'b0;
    tx_word  = frame_word(stat_q, addr_q);
    tx_shift = 1'b0;
    rx_shift = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start_i && !done_q) begin
          stat_d = stat_mode_i;
          addr_d = offset_i;
          left_d = count_i;
          if (!primed_q) begin
            st_d   = S_PRE;
            pre_d  = 2'd0;
            sclk_d = 1'b1;
          end else if (stat_mode_i || (count_i != '0)) begin
            st_d    = S_LO;
            bit_d   = '0;
            csn_d   = 1'b0;
            tx_load = 1'b1;
            tx_word = frame_word(stat_mode_i, offset_i);
          end else begin
            done_d = 1'b1;
          end
        end
      end
      S_PRE: begin
        if (tick) begin
          if (pre_q == 2'd3) begin
            primed_d = 1'b1;
            sclk_d   = 1'b0;
            if (stat_q || (left_q != '0)) begin
              st_d    = S_LO;
              bit_d   = '0;
              csn_d   = 1'b0;
              tx_load = 1'b1;
            end else begin
              st_d   = S_IDLE;
              done_d = 1'b1;
            end
          end else begin
            pre_d  = pre_q + 2'd1;
            sclk_d = pre_q[0];
          end
        end
      end
      S_LO: begin
        if (tick) begin
          rx_shift = (bit_q >= cmd_len);
          st_d     = S_HI;
          sclk_d   = 1'b1;
        end
      end
      S_HI: begin
        if (tick) begin
          sclk_d = 1'b0;
          if (bit_q == last_bit) begin
            st_d  = S_GAP;
            csn_d = 1'b1;
            vld_d = 1'b1;
          end else begin
            bit_d    = bit_q + BIT_W'(1);
            tx_shift = 1'b1;
            st_d     = S_LO;
          end
        end
      end
      S_GAP: begin
        if (tick) begin
          if (stat_q || (left_q == CNT_W'(1))) begin
            st_d   = S_IDLE;
            done_d = 1'b1;
          end else begin
            left_d  = left_q - CNT_W'(1);
            addr_d  = addr_q + 8'd1;
            st_d    = S_LO;
            bit_d   = '0;
            csn_d   = 1'b0;
            tx_load = 1'b1;
            tx_word = frame_word(1'b0, addr_q + 8'd1);
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q     <= S_IDLE;
      bit_q    <= '0;
      pre_q    <= 2'd0;
      primed_q <= 1'b0;
      stat_q   <= 1'b0;
      addr_q   <= 8'd0;
      left_q   <= '0;
      sclk_q   <= 1'b0;
      csn_q    <= 1'b1;
      done_q   <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      bit_q    <= bit_d;
      pre_q    <= pre_d;
      primed_q <= primed_d;
      stat_q   <= stat_d;
      addr_q   <= addr_d;
      left_q   <= left_d;
      sclk_q   <= sclk_d;
      csn_q    <= csn_d;
      done_q   <= done_d;
      vld_q    <= vld_d;
    end
  end

  assign busy_o     = (st_q != S_IDLE) || done_q;
  assign done_o     = done_q;
  assign byte_o     = rx_data;
  assign byte_vld_o = vld_q;
  assign cs_n_o     = csn_q;
  assign sclk_o     = sclk_q;
  assign mosi_o     = tx_msb;
endmodule

// File: rtl/srf_chk.sv
`timescale 1ns/1ps
module srf_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic byte_vld_o,
  input logic cs_n_o,
  input logic sclk_o,
  input logic mosi_o
);
  // R1: quiet lines outside a run
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (cs_n_o && !sclk_o && !byte_vld_o));

  // R3: data out held while the clock is high
  a_r3_mosi_held_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  // R3: select only moves with the clock low
  a_r3_cs_move_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n_o) || $rose(cs_n_o)) |-> !sclk_o);

  // R4: a byte is handed over as the device is released
  a_r4_vld_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |-> (cs_n_o && !sclk_o && busy_o));

  // R8: done lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: busy only drops right after done
  a_r8_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(done_o));

  // R9: a start during a run does not end it
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !done_o) |=> busy_o);
endmodule

bind spi_rom_fetch srf_chk u_srf_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .byte_vld_o(byte_vld_o), .cs_n_o(cs_n_o),
  .sclk_o(sclk_o), .mosi_o(mosi_o)
);

// File: tb/spi_rom_fetch_test.sv
`timescale 1ns/1ps
module spi_rom_fetch_test;
  localparam int HALF  = 3;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic stat_mode_i = 1'b0;
  logic [7:0] offset_i = 8'd0;
  logic [CNT_W-1:0] count_i = '0;
  logic busy_o, done_o, byte_vld_o, cs_n_o, sclk_o, mosi_o;
  logic [7:0] byte_o;
  logic miso_i = 1'b0;

  always #5 clk = ~clk;

  spi_rom_fetch #(.HALF_CYC(HALF), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stat_mode_i(stat_mode_i),
    .offset_i(offset_i), .count_i(count_i), .busy_o(busy_o), .done_o(done_o),
    .byte_o(byte_o), .byte_vld_o(byte_vld_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .miso_i(miso_i)
  );

  int checks = 0;
  int errs = 0;
  logic [7:0] mem [256];
  logic [7:0] stat_val = 8'h00;
  logic [7:0] e_off = 8'd0;
  bit e_stat = 1'b0;
  bit mid_run = 1'b0;
  int nb = 0;
  int tk = 0;
  int exp_pre = 2;
  int pre_rises = 0;
  int hi_len = 0, lo_len = 0, cs_hi = 0, cs_falls = 0;
  logic prev_sclk = 1'b0, prev_cs = 1'b1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int k);
    return e_stat ? stat_val : mem[8'(int'(e_off) + k)];
  endfunction

  // behavioural device model
  int rbit = 0;
  logic [7:0] rop = 8'd0, radr = 8'd0;

  always @(negedge cs_n_o) begin
    rbit = 0; rop = 8'd0; radr = 8'd0;
  end

  always @(posedge sclk_o) if (!cs_n_o) begin
    if (rbit < 8) rop = {rop[6:0], mosi_o};
    else if (rbit < 16 && rop == 8'h03) radr = {radr[6:0], mosi_o};
    rbit++;
  end

  always @(negedge sclk_o) if (!cs_n_o) begin
    if (rop == 8'h05 && rbit >= 8 && rbit < 16) miso_i = stat_val[15 - rbit];
    else if (rop == 8'h03 && rbit >= 16 && rbit < 24) miso_i = mem[radr][23 - rbit];
  end

  always @(posedge cs_n_o) if (rst_n && rbit > 0) begin
    if (e_stat) begin
      chk(rop == 8'h05, "R7 opcode", rop, 5);
      chk(rbit == 16, "R7 edge count", rbit, 16);
    end else begin
      chk(rop == 8'h03, "R3 opcode", rop, 3);
      chk(rbit == 24, "R3 edge count", rbit, 24);
      chk(radr == 8'(int'(e_off) + tk), "R5 R11 address", radr, 8'(int'(e_off) + tk));
    end
    tk++;
    rbit = 0;
  end

  // line monitor, sampled between edges
  always @(negedge clk) if (rst_n) begin
    if (byte_vld_o) begin
      chk(byte_o == exp_byte(nb), "R4 byte", byte_o, exp_byte(nb));
      nb++;
    end
    if (sclk_o) hi_len++;
    if (!sclk_o && prev_sclk) begin
      chk(hi_len == HALF, "R6 high phase", hi_len, HALF);
      hi_len = 0;
    end
    if (sclk_o && !prev_sclk) begin
      if (!cs_n_o) chk(lo_len == HALF, "R6 low phase", lo_len, HALF);
      else pre_rises++;
      lo_len = 0;
    end
    if (!sclk_o && !cs_n_o) lo_len++;
    if (cs_n_o) begin
      cs_hi++;
      lo_len = 0;
    end
    if (!cs_n_o && prev_cs) begin
      cs_falls++;
      chk(pre_rises == exp_pre, "R2 warm-up pulses", pre_rises, exp_pre);
      pre_rises = 0;
      exp_pre = 0;
      if (mid_run && nb > 0) chk(cs_hi == HALF, "R5 gap length", cs_hi, HALF);
      cs_hi = 0;
    end
    prev_sclk = sclk_o;
    prev_cs = cs_n_o;
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    pre_rises = 0; hi_len = 0; lo_len = 0; cs_hi = 0;
    prev_sclk = 1'b0; prev_cs = 1'b1; exp_pre = 2;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n_o == 1'b1, "R1 cs after reset", cs_n_o, 1);
    chk(sclk_o == 1'b0, "R1 sclk after reset", sclk_o, 0);
    chk(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
    chk(done_o == 1'b0 && byte_vld_o == 1'b0, "R1 strobes after reset", done_o | byte_vld_o, 0);
  endtask

  task automatic run_xfer(input logic [7:0] off, input int cnt, input bit stat, input bit poke);
    int cyc;
    int want;
    int falls0;
    want = stat ? 1 : cnt;
    falls0 = cs_falls;
    e_off = off; e_stat = stat; nb = 0; tk = 0; mid_run = 1'b1;
    @(negedge clk);
    start_i = 1'b1; offset_i = off; count_i = CNT_W'(cnt); stat_mode_i = stat;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
    if (poke) begin
      repeat (30) @(negedge clk);
      start_i = 1'b1; offset_i = ~off; stat_mode_i = ~stat; count_i = 8'd1;
      @(negedge clk);
      start_i = 1'b0;
    end
    cyc = 0;
    while (!done_o && cyc < 60000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done_o == 1'b1, "R8 done seen", done_o, 1);
    chk(busy_o == 1'b1, "R8 busy during done", busy_o, 1);
    @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R8 release after done", busy_o | done_o, 0);
    chk(nb == want, poke ? "R9 byte count" : "R5 byte count", nb, want);
    chk(tk == want, stat ? "R7 transactions" : "R5 transactions", tk, want);
    if (!stat && cnt == 0)
      chk(cs_falls == falls0, "R10 no select", cs_falls - falls0, 0);
    mid_run = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h1F2E3D4C);
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    stat_val = 8'hA5;

    do_reset();
    run_xfer(8'h10, 4, 1'b0, 1'b0);             // R2 warm-up, R3, R4, R5
    run_xfer(8'h00, 0, 1'b1, 1'b0);             // R7 status, inputs ignored
    run_xfer(8'hFA, 12, 1'b0, 1'b0);            // R11 wrap
    run_xfer(8'h33, 0, 1'b0, 1'b0);             // R10 empty run
    run_xfer(8'h40, 3, 1'b0, 1'b1);             // R9 start while busy
    run_xfer(8'hFF, 2, 1'b0, 1'b0);             // R11 wrap at the last address
    for (int i = 0; i < 20; i++) begin
      stat_val = 8'($urandom);
      run_xfer(8'($urandom), 1 + int'($urandom % 6), ($urandom % 5) == 0, 1'b0);
    end
    run_xfer(8'h80, 40, 1'b0, 1'b0);

    do_reset();                                 // R2 warm-up comes back
    stat_val = 8'h3C;
    run_xfer(8'h00, 0, 1'b1, 1'b0);
    run_xfer(8'h7E, 3, 1'b0, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule